// File: doc/BRIEF.md
# Periodic Wake-Up and Duty-Cycle Receive Controller

This block keeps time while the radio sleeps. It counts ticks of a 32.768 kHz slow clock, delivered as single-cycle enable pulses in the fast clock domain. It counts only if its enable bit was already set when the sleep state began. Each time a programmed period ends it sets a wake status flag. When the wake interrupt is unmasked, the flag drives an active-low interrupt line, which stays low until the host reads the status.

In duty-cycle mode, every period boundary also opens a short listening window in which `rx_on` powers the receiver. If the demodulator reports a valid preamble and then a sync word inside that window, the window is replaced by a longer hold so that the whole packet can arrive. If it does not, the receiver drops at the end of the window. The period counter reloads by itself at every boundary, so window length and hold length never shift the wake schedule.

Top module: `wkp_wake_ctrl`

## Requirements
- R1: After reset `rx_on` is 0, `irq_n` is 1 and `wake_flag` is 0.
- R2: The timer runs only if `timer_en` is 1 in the cycle where `sleeping` rises. Setting `timer_en` later in the same sleep produces no wake event.
- R3: The period is `mant` × 2^`expo` ticks of `slow_tick`. The wake event lands on exactly that tick after sleep entry, and it repeats at the same spacing.
- R4: When `mant` is 0, no wake event ever occurs.
- R5: A wake event sets `wake_flag`. The `irq_n` output is 0 only while `wake_flag` is 1 and `irq_mask_n` is 1, so with `irq_mask_n` at 0 the flag still sets but `irq_n` stays 1.
- R6: A one-cycle `status_rd` pulse clears `wake_flag` and releases `irq_n`. A wake event in the same cycle keeps the flag set.
- R7: With `duty_mode` at 1, `rx_on` rises at each wake event and falls on the `listen_ticks`-th later tick, unless the window is extended. With `duty_mode` at 0, or with `listen_ticks` at 0, `rx_on` stays 0.
- R8: A sync indication during the window, with a preamble indication seen earlier in that window or in the same cycle, replaces the window by a hold. In the hold, `rx_on` stays 1 and falls on the `hold_ticks`-th later tick. A sync indication without a preamble does not extend the window.
- R9: Window extensions do not move the period boundaries: the next wake event still falls `mant` × 2^`expo` ticks after the previous one.
- R10: Dropping `timer_en` or `sleeping` stops the counter and clears the window, so `rx_on` is 0 in the following cycle. No further wake event occurs until the next sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| sleeping | input | 1 | Device is in the sleep state |
| timer_en | input | 1 | Wake timer enable |
| duty_mode | input | 1 | Open a receive window at each wake |
| irq_mask_n | input | 1 | 1 lets the wake flag reach `irq_n` |
| mant | input | 16 | Period mantissa, 0 disables wake-up |
| expo | input | 5 | Period exponent (power of two) |
| listen_ticks | input | 8 | Window length in slow ticks |
| hold_ticks | input | 8 | Extension length in slow ticks |
| pre_ok | input | 1 | Demodulator saw a valid preamble |
| sync_ok | input | 1 | Demodulator saw a sync word |
| status_rd | input | 1 | Host status read, clears the flag |
| rx_on | output | 1 | Receiver power request |
| irq_n | output | 1 | Active-low wake interrupt |
| wake_flag | output | 1 | Wake status bit as the host reads it |

## Verification
A wrong period count shows as a `wake_flag` edge on the wrong slow tick, visible right after that tick. A period that drifts with extensions shows up one period later. A stuck window phase shows as `rx_on` staying high past its last tick, or failing to rise at the boundary, within one tick. A stale preamble latch shows as an extension after a bare sync word. It is seen on the tick where the window should have ended.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LISTEN = 2'd1,
    PH_HOLD   = 2'd2
  } wkp_phase_e;
endpackage

// File: rtl/wkp_period_timer.sv
module wkp_period_timer #(
  parameter int MW = 16,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sleeping,
  input  logic          timer_en,
  input  logic [MW-1:0] mant,
  input  logic [EW-1:0] expo,
  output logic          wake_evt,
  output logic          kill
);
  localparam int CW = MW + (1 << EW) - 1;

  logic          sleep_q;
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_full, last_cnt;
  logic          entry;

  assign per_full = CW'(mant) << expo;
  assign last_cnt = per_full - CW'(1);
  assign kill     = !timer_en || !sleeping;
  assign entry    = sleeping && !sleep_q && timer_en;
  assign wake_evt = run_q && !kill && tick && (mant != '0) && (cnt_q == last_cnt);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (kill) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (entry) begin
      run_d = (mant != '0);
      cnt_d = '0;
    end else if (run_q && tick) begin
      if (mant == '0) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else if (cnt_q == last_cnt) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sleep_q <= sleeping;
      run_q   <= run_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/wkp_rx_window.sv
module wkp_rx_window #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          kill,
  input  logic          wake_evt,
  input  logic          duty_mode,
  input  logic [LW-1:0] listen_ticks,
  input  logic [LW-1:0] hold_ticks,
  input  logic          pre_ok,
  input  logic          sync_ok,
  output logic          rx_on
);
  import wkp_pkg::*;

  wkp_phase_e    ph_q, ph_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          pre_q, pre_d;
  logic          found;

  assign found = sync_ok && (pre_q || pre_ok);
  assign rx_on = (ph_q != PH_IDLE);

  always_comb begin
    ph_d  = ph_q;
    rem_d = rem_q;
    pre_d = pre_q;
    if (kill) begin
      ph_d  = PH_IDLE;
      rem_d = '0;
      pre_d = 1'b0;
    end else if (wake_evt) begin
      pre_d = 1'b0;
      if (duty_mode && (listen_ticks != '0)) begin
        ph_d  = PH_LISTEN;
        rem_d = listen_ticks;
      end else begin
        ph_d  = PH_IDLE;
        rem_d = '0;
      end
    end else begin
      case (ph_q)
        PH_LISTEN: begin
          if (pre_ok) pre_d = 1'b1;
          if (found) begin
            pre_d = 1'b0;
            rem_d = hold_ticks;
            ph_d  = (hold_ticks != '0) ? PH_HOLD : PH_IDLE;
          end else if (tick) begin
            if (rem_q == LW'(1)) begin
              ph_d  = PH_IDLE;
              pre_d = 1'b0;
            end
            rem_d = rem_q - LW'(1);
          end
        end
        PH_HOLD: begin
          if (tick) begin
            if (rem_q == LW'(1)) ph_d = PH_IDLE;
            rem_d = rem_q - LW'(1);
          end
        end
        default: begin
          pre_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      rem_q <= '0;
      pre_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rem_q <= rem_d;
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/wkp_irq_flag.sv
module wkp_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_evt,
  input  logic status_rd,
  input  logic irq_mask_n,
  output logic wake_flag,
  output logic irq_n
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (wake_evt)       flag_d = 1'b1;
    else if (status_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign wake_flag = flag_q;
  assign irq_n     = !(flag_q && irq_mask_n);
endmodule

// File: rtl/wkp_wake_ctrl.sv
module wkp_wake_ctrl #(
  parameter int MW = 16,
  parameter int EW = 5,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          sleeping,
  input  logic          timer_en,
  input  logic          duty_mode,
  input  logic          irq_mask_n,
  input  logic [MW-1:0] mant,
  input  logic [EW-1:0] expo,
  input  logic [LW-1:0] listen_ticks,
  input  logic [LW-1:0] hold_ticks,
  input  logic          pre_ok,
  input  logic          sync_ok,
  input  logic          status_rd,
  output logic          rx_on,
  output logic          irq_n,
  output logic          wake_flag
);
  logic wake_evt;
  logic kill;

  wkp_period_timer #(.MW(MW), .EW(EW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slow_tick),
    .sleeping (sleeping),
    .timer_en (timer_en),
    .mant     (mant),
    .expo     (expo),
    .wake_evt (wake_evt),
    .kill     (kill)
  );

  wkp_rx_window #(.LW(LW)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (slow_tick),
    .kill         (kill),
    .wake_evt     (wake_evt),
    .duty_mode    (duty_mode),
    .listen_ticks (listen_ticks),
    .hold_ticks   (hold_ticks),
    .pre_ok       (pre_ok),
    .sync_ok      (sync_ok),
    .rx_on        (rx_on)
  );

  wkp_irq_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_evt   (wake_evt),
    .status_rd  (status_rd),
    .irq_mask_n (irq_mask_n),
    .wake_flag  (wake_flag),
    .irq_n      (irq_n)
  );
endmodule

// File: rtl/wkp_wake_ctrl_chk.sv
module wkp_wake_ctrl_chk #(
  parameter int MW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slow_tick,
  input logic          sleeping,
  input logic          timer_en,
  input logic          duty_mode,
  input logic          irq_mask_n,
  input logic [MW-1:0] mant,
  input logic          status_rd,
  input logic          rx_on,
  input logic          irq_n,
  input logic          wake_flag
);
  AST_KILL_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en || !sleeping) |=> !rx_on); // R10

  AST_WAKE_NEEDS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> ($past(slow_tick) && $past(timer_en) && ($past(mant) != '0))); // R4

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !slow_tick) |=> !wake_flag); // R6

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(slow_tick) || $rose(irq_mask_n))); // R5

  AST_RX_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> ($past(slow_tick) && $past(duty_mode))); // R7

  AST_RX_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on) |-> wake_flag); // R3
endmodule

bind wkp_wake_ctrl wkp_wake_ctrl_chk #(.MW(MW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_tick  (slow_tick),
  .sleeping   (sleeping),
  .timer_en   (timer_en),
  .duty_mode  (duty_mode),
  .irq_mask_n (irq_mask_n),
  .mant       (mant),
  .status_rd  (status_rd),
  .rx_on      (rx_on),
  .irq_n      (irq_n),
  .wake_flag  (wake_flag)
);

// File: tb/wkp_wake_ctrl_test.sv
module wkp_wake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        sleeping = 1'b0;
  logic        timer_en = 1'b0;
  logic        duty_mode = 1'b0;
  logic        irq_mask_n = 1'b0;
  logic [15:0] mant = '0;
  logic [4:0]  expo = '0;
  logic [7:0]  listen_ticks = '0;
  logic [7:0]  hold_ticks = '0;
  logic        pre_ok = 1'b0;
  logic        sync_ok = 1'b0;
  logic        status_rd = 1'b0;
  logic        rx_on, irq_n, wake_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  wkp_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sleeping(sleeping),
    .timer_en(timer_en), .duty_mode(duty_mode), .irq_mask_n(irq_mask_n),
    .mant(mant), .expo(expo), .listen_ticks(listen_ticks), .hold_ticks(hold_ticks),
    .pre_ok(pre_ok), .sync_ok(sync_ok), .status_rd(status_rd),
    .rx_on(rx_on), .irq_n(irq_n), .wake_flag(wake_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_tick = 1'b1;
      @(negedge clk) slow_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic read_status();
    @(negedge clk) status_rd = 1'b1;
    @(negedge clk) status_rd = 1'b0;
  endtask

  task automatic enter_sleep();
    @(negedge clk) sleeping = 1'b1;
    @(negedge clk);
  endtask

  task automatic park();
    @(negedge clk);
    sleeping = 1'b0; timer_en = 1'b0; duty_mode = 1'b0;
    read_status();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rx_on", rx_on, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 wake_flag", wake_flag, 1'b0);
  endtask

  task automatic t_period();
    mant = 16'd3; expo = 5'd1; irq_mask_n = 1'b1; timer_en = 1'b1;
    enter_sleep();
    ticks(5);
    chk("R3 no wake before 6 ticks", wake_flag, 1'b0);
    ticks(1);
    chk("R3 wake on tick 6", wake_flag, 1'b1);
    chk("R5 irq_n low", irq_n, 1'b0);
    read_status();
    chk("R6 flag cleared", wake_flag, 1'b0);
    chk("R6 irq_n released", irq_n, 1'b1);
    ticks(5);
    chk("R3 repeat not early", wake_flag, 1'b0);
    ticks(1);
    chk("R3 repeat on tick 12", wake_flag, 1'b1);
    park();
  endtask

  task automatic t_masked();
    mant = 16'd2; expo = 5'd0; irq_mask_n = 1'b0; timer_en = 1'b1;
    enter_sleep();
    ticks(2);
    chk("R5 flag set while masked", wake_flag, 1'b1);
    chk("R5 irq_n high while masked", irq_n, 1'b1);
    irq_mask_n = 1'b1;
    @(negedge clk);
    chk("R5 irq_n low after unmask", irq_n, 1'b0);
    park();
  endtask

  task automatic t_late_enable();
    mant = 16'd2; expo = 5'd0; timer_en = 1'b0;
    enter_sleep();
    @(negedge clk) timer_en = 1'b1;
    ticks(10);
    chk("R2 late enable gives no wake", wake_flag, 1'b0);
    park();
  endtask

  task automatic t_zero_mant();
    mant = 16'd0; expo = 5'd3; timer_en = 1'b1;
    enter_sleep();
    ticks(20);
    chk("R4 zero mantissa no wake", wake_flag, 1'b0);
    park();
  endtask

  task automatic t_window();
    mant = 16'd4; expo = 5'd0; listen_ticks = 8'd2; hold_ticks = 8'd5;
    duty_mode = 1'b1; timer_en = 1'b1;
    enter_sleep();
    ticks(3);
    chk("R7 rx off before boundary", rx_on, 1'b0);
    ticks(1);
    chk("R7 rx on at boundary", rx_on, 1'b1);
    ticks(1);
    chk("R7 rx on within window", rx_on, 1'b1);
    ticks(1);
    chk("R7 rx off after window", rx_on, 1'b0);
    ticks(2);
    chk("R7 rx on at next boundary", rx_on, 1'b1);
    park();
    mant = 16'd2; duty_mode = 1'b0; timer_en = 1'b1;
    enter_sleep();
    ticks(2);
    chk("R7 no rx without duty mode", rx_on, 1'b0);
    park();
  endtask

  task automatic t_extend();
    mant = 16'd1; expo = 5'd3; listen_ticks = 8'd2; hold_ticks = 8'd4;
    duty_mode = 1'b1; timer_en = 1'b1;
    enter_sleep();
    ticks(8);
    chk("R8 rx on at boundary", rx_on, 1'b1);
    read_status();
    @(negedge clk) pre_ok = 1'b1;
    @(negedge clk) pre_ok = 1'b0;
    @(negedge clk) sync_ok = 1'b1;
    @(negedge clk) sync_ok = 1'b0;
    ticks(3);
    chk("R8 rx held past window", rx_on, 1'b1);
    ticks(1);
    chk("R8 rx off after hold", rx_on, 1'b0);
    ticks(3);
    chk("R9 boundary not moved early", wake_flag, 1'b0);
    ticks(1);
    chk("R9 boundary on schedule", wake_flag, 1'b1);
    chk("R9 rx on at boundary", rx_on, 1'b1);
    @(negedge clk) sync_ok = 1'b1;
    @(negedge clk) sync_ok = 1'b0;
    ticks(2);
    chk("R8 bare sync does not extend", rx_on, 1'b0);
    park();
  endtask

  task automatic t_disable();
    mant = 16'd4; expo = 5'd0; listen_ticks = 8'd3;
    duty_mode = 1'b1; timer_en = 1'b1;
    enter_sleep();
    ticks(4);
    chk("R10 rx on before disable", rx_on, 1'b1);
    @(negedge clk) timer_en = 1'b0;
    @(negedge clk);
    chk("R10 rx off after disable", rx_on, 1'b0);
    read_status();
    timer_en = 1'b1;
    ticks(10);
    chk("R10 no wake after disable", wake_flag, 1'b0);
    park();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_masked();
    t_late_enable();
    t_zero_mant();
    t_window();
    t_extend();
    t_disable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule